// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block receives asynchronous serial characters of eight or nine data bits. The serial line is brought in through a synchroniser. A free-running tick at sixteen times the bit rate paces the receiver, which times each bit from the start edge. Every bit is sampled three times around its middle, and the value taken is the majority of the three. A character that has finished goes into a receive data register, and the receive-complete flag sets. The framing-error and overrun flags record how the character arrived.

A host reads the block through a one-bit address. Address 0 returns the received data and address 1 returns the status byte. Writes to the data address would go to a transmitter, so this block takes no write strobe. The two transmit status bits are fixed at 1. Software can clear receive-complete in two ways: it acknowledges the interrupt, or it reads the status register while the flag is set and then reads the data register. When the enable is low, the receiver stays idle and gives the serial pin back for general use.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset, the status byte reads 0x60, the data register reads 0x00, and `rx_irq` and `rx_bit8` are 0.
- R2: A frame is a low start bit, then the data bits least significant first, then a stop bit. At the end of the stop bit the data bits go into the data register and receive-complete (status bit 7) sets.
- R3: Each bit is decided by a 2-of-3 majority of the samples taken on the 8th, 9th and 10th ticks of its bit period. A disturbance that covers only one tick does not change the received value.
- R4: A falling edge starts a frame only if the start-bit vote is low. If the vote is high, the receiver goes back to idle and delivers nothing.
- R5: A stop-bit vote of 0 sets framing error (status bit 4). The data is still delivered, and receive-complete still sets. The next character loads the framing-error bit again.
- R6: When `frame9` is 1, nine data bits are received and the ninth is loaded into `rx_bit8` at the moment of transfer. When `frame9` is 0, `rx_bit8` keeps its value.
- R7: A transfer sets overrun (status bit 3) when the data register was not read after the previous transfer, and clears overrun otherwise. The new data replaces the old.
- R8: A data read clears receive-complete only if the status was read while receive-complete was 1 since the last transfer. A status read alone does not clear it, and neither does a data read alone.
- R9: A pulse on `irq_ack` clears receive-complete.
- R10: `rx_irq` is 1 exactly when `irq_en` is 1 and receive-complete is 1.
- R11: While `rx_en` is 0, the receiver stays idle, no character is delivered, and `rx_pin_claim` is 0. While `rx_en` is 1, `rx_pin_claim` is 1.
- R12: Address 0 returns the data register. Address 1 returns the status byte: bit 7 receive-complete, bits 6 and 5 fixed at 1, bit 4 framing error, bit 3 overrun, bits 2 to 0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd_pad | input | 1 | Asynchronous serial input |
| rx_en | input | 1 | Receiver enable |
| frame9 | input | 1 | 1 selects nine data bits |
| irq_en | input | 1 | Receive-complete interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears receive-complete |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 data register, 1 status register |
| bus_rdata | output | 8 | Read data for the addressed register |
| rx_bit8 | output | 1 | Ninth received bit |
| rx_irq | output | 1 | Receive-complete interrupt |
| rx_pin_claim | output | 1 | 1 while the receiver owns the serial pin |

## Verification
The assertions assume that `frame9` holds steady while a frame is in flight, that `os_tick` is a single-cycle pulse, and that at most one of `bus_rd` and `irq_ack` is active around a transfer whose outcome is being checked. The stimulus changes mode only between frames. It leaves at least one idle bit after each stop bit, so that no start edge arrives before the receiver is idle again. It injects disturbances exactly one tick wide, so that at most one of the three votes in a bit is affected.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the oversampled serial receiver.
// Assumes a single clock domain; the serial pad is synchronised inside the top.
package uart_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Two-of-three majority of a vote vector.
    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
// Multi-stage synchroniser for the serial pad.
// Assumes the idle line level is 1, so every stage resets to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the pad value through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
// Frame engine: finds the start edge, counts oversampling ticks, takes three
// votes per bit and assembles the data bits LSB first.
// Assumes os_tick is a one-cycle pulse and frame9 is stable during a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd_s,
    input  logic              rx_en,
    input  logic              frame9,
    output logic              frm_done,
    output logic              frm_ferr,
    output logic [DATA_W:0]   frm_data
);
    localparam int CW     = $clog2(OSR);
    localparam int IW     = $clog2(DATA_W + 1);
    localparam int VOTE_A = OSR / 2 - 1;
    localparam int VOTE_C = OSR / 2 + 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_8    = IW'(DATA_W - 1);
    localparam logic [IW-1:0] IDX_9    = IW'(DATA_W);

    rx_state_e      state_q;
    logic [CW-1:0]  os_cnt_q;
    logic [IW-1:0]  bit_idx_q;
    logic [2:0]     votes_q;
    logic [DATA_W:0] shreg_q;
    logic           rxd_prev_q;
    logic           in_window;
    logic           bit_val;
    logic [IW-1:0]  last_idx;

    // Decode the sampling window and the majority of the collected votes.
    always_comb begin
        in_window = (int'(os_cnt_q) >= VOTE_A) && (int'(os_cnt_q) <= VOTE_C);
        bit_val   = maj3(votes_q);
        last_idx  = frame9 ? IDX_9 : IDX_8;
    end

    // Frame sequencing, vote collection and data assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            os_cnt_q   <= '0;
            bit_idx_q  <= '0;
            votes_q    <= '0;
            shreg_q    <= '0;
            rxd_prev_q <= 1'b1;
            frm_done   <= 1'b0;
            frm_ferr   <= 1'b0;
        end else begin
            rxd_prev_q <= rxd_s;
            frm_done   <= 1'b0;
            if (!rx_en) begin
                state_q <= ST_IDLE;
            end else if (state_q == ST_IDLE) begin
                if (rxd_prev_q && !rxd_s) begin
                    state_q   <= ST_START;
                    os_cnt_q  <= '0;
                    bit_idx_q <= '0;
                    votes_q   <= '0;
                end
            end else if (os_tick) begin
                if (in_window) votes_q <= {votes_q[1:0], rxd_s};
                os_cnt_q <= (os_cnt_q == CNT_LAST) ? '0 : os_cnt_q + 1'b1;
                if (os_cnt_q == CNT_LAST) begin
                    case (state_q)
                        ST_START: state_q <= bit_val ? ST_IDLE : ST_DATA;
                        ST_DATA: begin
                            shreg_q[bit_idx_q] <= bit_val;
                            if (bit_idx_q == last_idx) state_q <= ST_STOP;
                            else bit_idx_q <= bit_idx_q + 1'b1;
                        end
                        ST_STOP: begin
                            frm_done <= 1'b1;
                            frm_ferr <= !bit_val;
                            state_q  <= ST_IDLE;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign frm_data = shreg_q;

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == ST_IDLE)); // R11
    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> ($past(state_q) == ST_STOP)); // R2
endmodule

// File: rtl/uart_rx_regs.sv
// Register side: data register, ninth bit, status flags, clear sequence and
// interrupt. Assumes a read is a one-cycle bus_rd pulse with a valid address.
module uart_rx_regs
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_done,
    input  logic              frm_ferr,
    input  logic [DATA_W:0]   frm_data,
    input  logic              frame9,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic              irq_en,
    input  logic              irq_ack,
    output logic [7:0]        bus_rdata,
    output logic              rx_bit8,
    output logic              rx_irq
);
    logic [DATA_W-1:0] data_q;
    logic              bit8_q;
    logic              rxc_q;
    logic              fe_q;
    logic              or_q;
    logic              unread_q;
    logic              armed_q;
    logic              stat_rd;
    logic              data_rd;

    // Decode the two read events.
    always_comb begin
        stat_rd = bus_rd && (bus_addr == ADDR_STAT);
        data_rd = bus_rd && (bus_addr == ADDR_DATA);
    end

    // Flag and data register updates; a transfer takes priority over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            bit8_q   <= 1'b0;
            rxc_q    <= 1'b0;
            fe_q     <= 1'b0;
            or_q     <= 1'b0;
            unread_q <= 1'b0;
            armed_q  <= 1'b0;
        end else if (frm_done) begin
            data_q   <= frm_data[DATA_W-1:0];
            if (frame9) bit8_q <= frm_data[DATA_W];
            fe_q     <= frm_ferr;
            or_q     <= unread_q && !data_rd;
            unread_q <= 1'b1;
            rxc_q    <= 1'b1;
            armed_q  <= 1'b0;
        end else begin
            if (stat_rd && rxc_q) armed_q <= 1'b1;
            if (data_rd) begin
                unread_q <= 1'b0;
                if (armed_q) begin
                    rxc_q   <= 1'b0;
                    armed_q <= 1'b0;
                end
            end
            if (irq_ack) begin
                rxc_q   <= 1'b0;
                armed_q <= 1'b0;
            end
        end
    end

    // Read multiplexer for the data and status addresses.
    always_comb begin
        if (bus_addr == ADDR_STAT) bus_rdata = {rxc_q, 1'b1, 1'b1, fe_q, or_q, 3'b000};
        else                       bus_rdata = 8'(data_q);
    end

    assign rx_bit8 = bit8_q;
    assign rx_irq  = irq_en && rxc_q;

    AST_DONE_SETS_RXC: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> rxc_q); // R2
    AST_FERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_ferr) |=> fe_q); // R5
    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && unread_q && !data_rd) |=> or_q); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !frm_done) |=> !rxc_q); // R9
    AST_LONE_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rxc_q && !armed_q && !irq_ack && !frm_done) |=> rxc_q); // R8
endmodule

// File: rtl/uart_rx_stat.sv
// Top of the oversampled serial receiver: synchroniser, frame engine and
// register side. Assumes os_tick comes from an external rate generator.
module uart_rx_stat #(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd_pad,
    input  logic       rx_en,
    input  logic       frame9,
    input  logic       irq_en,
    input  logic       irq_ack,
    input  logic       bus_rd,
    input  logic       bus_addr,
    output logic [7:0] bus_rdata,
    output logic       rx_bit8,
    output logic       rx_irq,
    output logic       rx_pin_claim
);
    logic            rxd_s;
    logic            frm_done;
    logic            frm_ferr;
    logic [DATA_W:0] frm_data;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_pad),
        .dout (rxd_s)
    );

    uart_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rxd_s   (rxd_s),
        .rx_en   (rx_en),
        .frame9  (frame9),
        .frm_done(frm_done),
        .frm_ferr(frm_ferr),
        .frm_data(frm_data)
    );

    uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_done (frm_done),
        .frm_ferr (frm_ferr),
        .frm_data (frm_data),
        .frame9   (frame9),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .irq_en   (irq_en),
        .irq_ack  (irq_ack),
        .bus_rdata(bus_rdata),
        .rx_bit8  (rx_bit8),
        .rx_irq   (rx_irq)
    );

    assign rx_pin_claim = rx_en;
endmodule

// File: tb/uart_rx_stat_tb.sv
module uart_rx_stat_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TD         = 2;
    localparam int BITCLK     = 16 * TD;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd_pad = 1'b1;
    logic rx_en = 1'b0, frame9 = 1'b0, irq_en = 1'b0, irq_ack = 1'b0;
    logic bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_rdata;
    logic rx_bit8, rx_irq, rx_pin_claim;
    int checks = 0, errors = 0, cyc = 0, tcnt = 0;
    logic [7:0] rd;

    uart_rx_stat u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_pad(rxd_pad),
        .rx_en(rx_en), .frame9(frame9), .irq_en(irq_en), .irq_ack(irq_ack),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .rx_bit8(rx_bit8), .rx_irq(rx_irq), .rx_pin_claim(rx_pin_claim)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Tick generator, one pulse every TD cycles, driven away from the edge.
    always @(negedge clk) begin
        tcnt    <= (tcnt == TD - 1) ? 0 : tcnt + 1;
        os_tick <= (tcnt == TD - 1);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic hold(input logic v, input int n);
        rxd_pad = v;
        repeat (n) @(negedge clk);
    endtask

    // Send one frame; glitch_bit >= 0 flips that data bit for one tick mid-bit.
    task automatic send(input logic [8:0] val, input logic nine, input logic stop, input int glitch_bit);
        int nb = nine ? 9 : 8;
        @(negedge clk);
        hold(1'b0, BITCLK);
        for (int i = 0; i < nb; i++) begin
            if (i == glitch_bit) begin
                hold(val[i], 8 * TD);
                hold(!val[i], TD);
                hold(val[i], 7 * TD);
            end else begin
                hold(val[i], BITCLK);
            end
        end
        hold(stop, BITCLK);
        hold(1'b1, 2 * BITCLK);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        bus_read(1'b1, rd); check("R1 status", rd, 9'h60);
        bus_read(1'b0, rd); check("R1 data", rd, 9'h00);
        check("R1 irq", rx_irq, 0);
        check("R1 bit8", rx_bit8, 0);

        rx_en = 1'b1;
        @(negedge clk);
        check("R11 claim", rx_pin_claim, 1);

        // R2 R8 R12 sweep of every 8-bit value
        for (int v = 0; v < 256; v++) begin
            send(9'(v), 1'b0, 1'b1, -1);
            bus_read(1'b1, rd); check("R2 status after frame", rd, 9'hE0);
            bus_read(1'b0, rd); check("R12 data value", rd, 9'(v));
            bus_read(1'b1, rd); check("R8 rxc cleared", rd, 9'h60);
        end

        // R6 nine-bit frames
        frame9 = 1'b1;
        send(9'h1A5, 1'b1, 1'b1, -1);
        bus_read(1'b1, rd); bus_read(1'b0, rd);
        check("R6 data", rd, 9'hA5); check("R6 bit8 one", rx_bit8, 1);
        send(9'h05A, 1'b1, 1'b1, -1);
        bus_read(1'b1, rd); bus_read(1'b0, rd);
        check("R6 data2", rd, 9'h5A); check("R6 bit8 zero", rx_bit8, 0);
        send(9'h1C3, 1'b1, 1'b1, -1);
        bus_read(1'b1, rd); bus_read(1'b0, rd);
        frame9 = 1'b0;
        send(9'h0F0, 1'b0, 1'b1, -1);
        bus_read(1'b1, rd); bus_read(1'b0, rd);
        check("R6 data 8bit", rd, 9'hF0); check("R6 bit8 held", rx_bit8, 1);

        // R3 one-tick disturbances are outvoted
        send(9'h000, 1'b0, 1'b1, 3);
        bus_read(1'b1, rd); bus_read(1'b0, rd); check("R3 glitch low", rd, 9'h00);
        send(9'h0FF, 1'b0, 1'b1, 5);
        bus_read(1'b1, rd); bus_read(1'b0, rd); check("R3 glitch high", rd, 9'hFF);

        // R5 framing error still delivers data
        send(9'h03C, 1'b0, 1'b0, -1);
        bus_read(1'b1, rd); check("R5 fe status", rd, 9'hF0);
        bus_read(1'b0, rd); check("R5 fe data", rd, 9'h3C);
        send(9'h0C3, 1'b0, 1'b1, -1);
        bus_read(1'b1, rd); check("R5 fe reloaded", rd, 9'hE0);
        bus_read(1'b0, rd);

        // R7 overrun
        send(9'h011, 1'b0, 1'b1, -1);
        send(9'h022, 1'b0, 1'b1, -1);
        bus_read(1'b1, rd); check("R7 overrun set", rd, 9'hE8);
        bus_read(1'b0, rd); check("R7 newest data", rd, 9'h22);
        send(9'h033, 1'b0, 1'b1, -1);
        bus_read(1'b1, rd); check("R7 overrun clear", rd, 9'hE0);
        bus_read(1'b0, rd);

        // R8 partial sequences do not clear
        send(9'h044, 1'b0, 1'b1, -1);
        bus_read(1'b0, rd); check("R8 data read alone", rd, 9'h44);
        bus_read(1'b1, rd); check("R8 rxc kept", rd, 9'hE0);
        bus_read(1'b1, rd); check("R8 status read alone", rd, 9'hE0);
        bus_read(1'b0, rd);
        bus_read(1'b1, rd); check("R8 full sequence", rd, 9'h60);

        // R10 R9 interrupt and acknowledge
        send(9'h055, 1'b0, 1'b1, -1);
        check("R10 irq masked", rx_irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R10 irq raised", rx_irq, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R9 irq dropped", rx_irq, 0);
        bus_read(1'b1, rd); check("R9 rxc cleared", rd, 9'h60);
        bus_read(1'b0, rd); check("R9 data kept", rd, 9'h55);
        irq_en = 1'b0;

        // R11 disabled receiver
        rx_en = 1'b0;
        @(negedge clk);
        check("R11 released", rx_pin_claim, 0);
        send(9'h066, 1'b0, 1'b1, -1);
        bus_read(1'b1, rd); check("R11 nothing received", rd, 9'h60);
        bus_read(1'b0, rd); check("R11 data unchanged", rd, 9'h55);
        rx_en = 1'b1;

        // R4 false start
        @(negedge clk);
        hold(1'b0, 3 * TD);
        hold(1'b1, 3 * BITCLK);
        bus_read(1'b1, rd); check("R4 false start ignored", rd, 9'h60);
        send(9'h077, 1'b0, 1'b1, -1);
        bus_read(1'b1, rd); check("R4 later frame", rd, 9'hE0);
        bus_read(1'b0, rd); check("R4 later data", rd, 9'h77);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule